// File: doc/BRIEF.md
# Nibble Arithmetic-Logic Unit with Carry

This block is a purely combinational 4-bit arithmetic-logic unit. Two nibble operands, a carry input and a 3-bit function code go in. A nibble result and one carry/borrow bit come out. The function code picks one of eight operations: four arithmetic and four bitwise. The unary operations (increment, decrement, complement) read only the second operand, `opnd_b`. The first operand and the carry input have no effect on them.

The block is meant to sit inside a larger datapath that owns its own registers. Nothing inside it is clocked. Its outputs follow any change on its inputs within the same cycle. Its only flag is the carry/borrow bit. Its meaning depends on the function: a carry for add and increment, a borrow for subtract and decrement, and zero for every bitwise function.

Top module: `nib_alu`

## Requirements
- R1: With `func_sel` = 3'b000, `result` equals (A + B + carry_in) mod 16 and `carry_out` equals bit 4 of the 5-bit sum.
- R2: With `func_sel` = 3'b001, `result` equals (A − B − carry_in) mod 16 and `carry_out` is 1 exactly when the true difference is negative.
- R3: With `func_sel` = 3'b010, `result` equals (B + 1) mod 16 and `carry_out` is 1 exactly when B = 15; A and carry_in have no effect.
- R4: With `func_sel` = 3'b011, `result` equals (B − 1) mod 16 and `carry_out` is 1 exactly when B = 0; A and carry_in have no effect.
- R5: With `func_sel` = 3'b100, 3'b101 and 3'b110, `result` is the bitwise AND, OR and XOR of A and B respectively, `carry_out` is 0, and carry_in has no effect.
- R6: With `func_sel` = 3'b111, `result` is the bitwise complement of B, `carry_out` is 0, and A and carry_in have no effect.
- R7: The outputs are combinational: a new input value is reflected on `result` and `carry_out` without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First operand; read only by the binary functions |
| opnd_b | input | 4 | Second operand; the sole source for the unary functions |
| carry_in | input | 1 | Carry or borrow into add and subtract |
| func_sel | input | 3 | Function code (encoding in R1–R6) |
| result | output | 4 | Nibble result |
| carry_out | output | 1 | Carry (add, increment), borrow (subtract, decrement), 0 otherwise |

## Verification
An exhaustive sweep drives every combination of the two operands, carry_in and function code. It exposes any wrong bit in a single vector, and it confirms that A and carry_in have no effect on the unary and bitwise functions. Directed vectors target the wrap points: add of 15+15+1, subtract of 0−15−1, increment of 15 and decrement of 0. These separate a correct carry/borrow from an off-by-one or inverted flag. A seeded random phase changes the inputs back to back between samples, so any stale output from the previous vector would show. A last directed pair changes only A under the complement function, and shows that the output stays the same.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    parameter int unsigned NIB_W = 4;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned EXT_W = NIB_W + 1;

    typedef enum logic [SEL_W-1:0] {
        FN_ADD = 3'b000,
        FN_SUB = 3'b001,
        FN_INC = 3'b010,
        FN_DEC = 3'b011,
        FN_AND = 3'b100,
        FN_OR  = 3'b101,
        FN_XOR = 3'b110,
        FN_NOT = 3'b111
    } fn_e;

    typedef struct packed {
        logic             cy;
        logic [NIB_W-1:0] val;
    } alu_res_t;

    // top bit of the code splits bitwise functions from arithmetic ones
    function automatic logic is_bitwise(fn_e f);
        return f[SEL_W-1];
    endfunction

    function automatic logic [1:0] sub_kind(fn_e f);
        return f[1:0];
    endfunction

endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith
    import nib_alu_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  logic             cin,
    input  logic [1:0]       kind,
    output alu_res_t         res
);

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] wide;

    always_comb begin
        ext_a = {1'b0, a};
        ext_b = {1'b0, b};
        unique case (kind)
            2'b00:   wide = ext_a + ext_b + EXT_W'(cin);
            2'b01:   wide = ext_a - ext_b - EXT_W'(cin);
            2'b10:   wide = ext_b + EXT_W'(1);
            default: wide = ext_b - EXT_W'(1);
        endcase
        res.val = wide[NIB_W-1:0];
        res.cy  = wide[NIB_W];
    end

    always_comb begin
        // R1: without a carry out the sum cannot fall below A
        if (kind == 2'b00 && !res.cy)
            a_r1_sum_not_below_a: assert (res.val >= a);
        // R2: without a borrow the difference cannot exceed A
        if (kind == 2'b01 && !res.cy)
            a_r2_diff_not_above_a: assert (res.val <= a);
        // R3: increment carries only when it lands on zero
        if (kind == 2'b10)
            a_r3_inc_wrap: assert (res.cy == (res.val == '0));
        // R4: decrement borrows only when it lands on all ones
        if (kind == 2'b11)
            a_r4_dec_wrap: assert (res.cy == (res.val == '1));
    end

endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
    import nib_alu_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  logic [1:0]       kind,
    output alu_res_t         res
);

    always_comb begin
        res.cy = 1'b0;
        unique case (kind)
            2'b00:   res.val = a & b;
            2'b01:   res.val = a | b;
            2'b10:   res.val = a ^ b;
            default: res.val = ~b;
        endcase
    end

    always_comb begin
        // R5: an AND result has no bit that A lacks
        if (kind == 2'b00)
            a_r5_and_within_a: assert ((res.val & ~a) == '0);
        // R5: an OR result covers every bit of B
        if (kind == 2'b01)
            a_r5_or_covers_b: assert ((res.val & b) == b);
        // R6: a complement shares no set bit with B
        if (kind == 2'b11)
            a_r6_not_disjoint: assert ((res.val & b) == '0);
    end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
(
    input  logic [NIB_W-1:0] opnd_a,
    input  logic [NIB_W-1:0] opnd_b,
    input  logic             carry_in,
    input  logic [SEL_W-1:0] func_sel,
    output logic [NIB_W-1:0] result,
    output logic             carry_out
);

    fn_e      fn;
    alu_res_t arith_res;
    alu_res_t logic_res;
    alu_res_t pick;

    assign fn = fn_e'(func_sel);

    nib_alu_arith u_arith (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (carry_in),
        .kind (sub_kind(fn)),
        .res  (arith_res)
    );

    nib_alu_logic u_logic (
        .a    (opnd_a),
        .b    (opnd_b),
        .kind (sub_kind(fn)),
        .res  (logic_res)
    );

    always_comb begin
        pick      = is_bitwise(fn) ? logic_res : arith_res;
        result    = pick.val;
        carry_out = pick.cy;
    end

    always_comb begin
        // R5, R6: bitwise functions never raise the carry
        if (func_sel[SEL_W-1])
            a_r5_bitwise_no_carry: assert (carry_out == 1'b0);
    end

endmodule

// File: tb/nib_alu_tb_top.sv
`timescale 1ns/1ps
module nib_alu_tb_top;

    logic       clk;
    logic       rst;
    logic [3:0] opnd_a;
    logic [3:0] opnd_b;
    logic       carry_in;
    logic [2:0] func_sel;
    logic [3:0] result;
    logic       carry_out;

    int n_vec;
    int n_bad;
    bit done;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    nib_alu dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .func_sel  (func_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [4:0] model(int f, int a, int b, int c);
        int s;
        logic co;
        logic [3:0] r;
        co = 1'b0;
        case (f)
            0: begin s = a + b + c; co = (s > 15); r = 4'(s % 16); end
            1: begin s = a - b - c; co = (s < 0);  r = 4'((s + 32) % 16); end
            2: begin co = (b == 15); r = 4'((b + 1) % 16); end
            3: begin co = (b == 0);  r = 4'((b + 15) % 16); end
            4: r = 4'(a & b);
            5: r = 4'(a | b);
            6: r = 4'(a ^ b);
            default: r = 4'(~b & 15);
        endcase
        return {co, r};
    endfunction

    function automatic string tag(int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            7: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req);
        logic [4:0] exp;
        exp = model(int'(func_sel), int'(opnd_a), int'(opnd_b), int'(carry_in));
        n_vec++;
        if ({carry_out, result} !== exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d: got cy=%0b res=%0d, expected cy=%0b res=%0d",
                     req, func_sel, opnd_a, opnd_b, carry_in,
                     carry_out, result, exp[4], exp[3:0]);
        end
    endtask

    task automatic apply(int f, int a, int b, int c, string req);
        func_sel = 3'(f);
        opnd_a   = 4'(a);
        opnd_b   = 4'(b);
        carry_in = 1'(c);
        #1;
        check(req);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        rst   = 1'b1;
        opnd_a = '0; opnd_b = '0; carry_in = 1'b0; func_sel = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle inputs: add of zeros gives zero with no carry (R1)
        #1 check("R1");

        // exhaustive sweep of every function, operand and carry (R1..R6)
        for (int f = 0; f < 8; f++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int c = 0; c < 2; c++)
                        apply(f, a, b, c, tag(f));

        // directed wrap points
        apply(0, 15, 15, 1, "R1");   // 31: result 15, carry
        apply(0, 15, 0, 1, "R1");    // 16: result 0, carry
        apply(1, 0, 15, 1, "R2");    // -16: result 0, borrow
        apply(1, 5, 5, 0, "R2");     // 0: no borrow
        apply(1, 5, 5, 1, "R2");     // -1: result 15, borrow
        apply(2, 9, 15, 1, "R3");    // wrap to 0 with carry, A and cin ignored
        apply(3, 9, 0, 1, "R4");     // wrap to 15 with borrow
        apply(7, 0, 10, 0, "R6");
        apply(7, 15, 10, 1, "R6");   // only A and cin changed: same output
        apply(4, 12, 10, 1, "R5");

        // seeded random, inputs changed back to back without a clock edge (R7)
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 600; i++) begin
            int f;
            f = int'($urandom_range(7, 0));
            apply(f, int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
                  int'($urandom_range(1, 0)), "R7");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule